// File: doc/BRIEF.md
# Banked Stack Pointer with Floating-Point Status

This unit holds the stack pointer of a 64-bit core in two banks. The user bank is a full 64-bit register. Its upper 16 bits also serve as the floating-point status word, so any write that reaches those bits changes the FP status. The interrupt bank is a 48-bit register. When an interrupt is taken, every register reference to the stack-pointer index is steered to the interrupt bank, and an interrupt return steers it back. Only one interrupt level exists.

The unit also decides how each kind of access reaches the status bits. The outcome depends on whether the core is in an interrupt and on whether the decoder runs the native instruction set or RISC-V. FPU flag reports are folded into sticky flag bits, but only outside an interrupt. While an interrupt runs, the FPU is told to treat denormals as zero and to flush results to zero, whatever the stored status says.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset both stack-pointer banks and the FP status are zero, interrupt mode is off, native decode mode is selected, `rd_data_o` is zero and `nest_err_o` is low.
- R2: `fpsr_o` always equals bits 63:48 of the user stack pointer. In native mode a read of index 15 outside an interrupt returns all 64 bits of the user stack pointer. A read of any other index returns zero.
- R3: In native mode outside an interrupt, a write to index 15 of either class replaces all 64 bits of the user stack pointer, including the status bits. A write to any other index changes nothing.
- R4: The interrupt stack pointer keeps 48 bits. A read of it returns zero in bits 63:48, and the write data in bits 63:48 is discarded.
- R5: An asserted `irq_enter_i` outside an interrupt sets `isr_o` from the next cycle. From then on, index 15 reads and writes the interrupt bank. `irq_return_i` inside an interrupt clears `isr_o` from the next cycle, and the user stack pointer reads back unchanged.
- R6: `irq_enter_i` while `isr_o` is high leaves interrupt mode on and makes `nest_err_o` high for the next cycle. `irq_return_i` while `isr_o` is low is ignored.
- R7: Outside an interrupt, with no write to index 15 in the same cycle, `flg_en_i` ORs `flg_bits_i` into status bits 4:0 (user stack pointer bits 52:48). All other bits keep their value.
- R8: Inside an interrupt, FPU flag reports leave `fpsr_o` unchanged.
- R9: When a user stack-pointer write and a flag report arrive in the same cycle, the write wins and the flags are discarded.
- R10: `fpu_mode_o` is {DAZ, FTZ}. Outside an interrupt it is {status bit 9, status bit 8}. Inside an interrupt it is 2'b11.
- R11: In RISC-V mode, an arithmetic-class access (class bit 0) to index 15 reads bits 63:48 as zero. An arithmetic-class write keeps the stored bits 63:48 and replaces bits 47:0.
- R12: In RISC-V mode, a logical-class access (class bit 1) to index 15 reads and writes all 64 bits.
- R13: `rd_data_o` shows the value from before any same-cycle write and is valid one cycle after the read is presented. Writes, flag reports and mode loads act at the next clock edge, so an access in the same cycle as `mode_load_i` still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load_i | input | 1 | Load the decode mode from `mode_rv_i` |
| mode_rv_i | input | 1 | 1 = RISC-V decode, 0 = native |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 6 | Read register index |
| rd_cls_i | input | 1 | Class of the reading op (0 arithmetic, 1 logical) |
| rd_data_o | output | 64 | Registered read result |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 6 | Write register index |
| wr_cls_i | input | 1 | Class of the writing op (0 arithmetic, 1 logical) |
| wr_data_i | input | 64 | Write data |
| flg_en_i | input | 1 | FPU flag report valid |
| flg_bits_i | input | 5 | Sticky flags to accumulate |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| irq_return_i | input | 1 | Interrupt return strobe |
| isr_o | output | 1 | Interrupt mode active |
| nest_err_o | output | 1 | Nested entry was rejected in the previous cycle |
| fpsr_o | output | 16 | Stored FP status word |
| fpu_mode_o | output | 2 | {DAZ, FTZ} presented to the FPU |

## Verification
Every result of this unit is due exactly one clock edge after its stimulus. `rd_data_o` reflects the bank state that existed when the read was presented. `fpsr_o`, `isr_o`, `nest_err_o` and `fpu_mode_o` reflect the state after the write, flag report, strobe or mode load of that same cycle. The bench drives each stimulus on a falling edge and compares all five outputs on the next falling edge. It compares them against a bench model that is advanced by one step per stimulus, so each compare covers one rising edge. Same-cycle collisions are driven on purpose: write with flag report, mode load with access, nested entry with return, and read with write.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  typedef enum logic {
    OPC_ARITH = 1'b0,
    OPC_LOGIC = 1'b1
  } opc_e;

  function automatic logic is_arith(input logic cls);
    return opc_e'(cls) == OPC_ARITH;
  endfunction
endpackage

// File: rtl/sp_isr_ctrl.sv
module sp_isr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic irq_enter_i,
  input  logic irq_return_i,
  input  logic mode_load_i,
  input  logic mode_rv_i,
  output logic isr_o,
  output logic nest_err_o,
  output logic rv_mode_o
);
  logic isr_q, nest_q, rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= 1'b0;
      nest_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      nest_q <= isr_q & irq_enter_i;
      if (isr_q) begin
        if (irq_return_i) isr_q <= 1'b0;
      end else if (irq_enter_i) begin
        isr_q <= 1'b1;
      end
      if (mode_load_i) rv_q <= mode_rv_i;
    end
  end

  assign isr_o      = isr_q;
  assign nest_err_o = nest_q;
  assign rv_mode_o  = rv_q;
endmodule

// File: rtl/sp_write_path.sv
module sp_write_path
  import sp_bank_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int ISP_W    = 48,
  parameter int FLAG_W   = 5,
  parameter int FLAG_LSB = 0
) (
  input  logic [XLEN-1:0]   usp_q_i,
  input  logic [ISP_W-1:0]  isp_q_i,
  input  logic              isr_i,
  input  logic              rv_i,
  input  logic              sp_wr_i,
  input  logic              wr_cls_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              flg_en_i,
  input  logic [FLAG_W-1:0] flg_bits_i,
  output logic [XLEN-1:0]   usp_d_o,
  output logic [ISP_W-1:0]  isp_d_o
);
  localparam int STAT_W = XLEN - ISP_W;

  logic user_wr, take_hi, flag_ok;

  assign user_wr = sp_wr_i & ~isr_i;
  assign take_hi = user_wr & ~(rv_i & is_arith(wr_cls_i));
  assign flag_ok = flg_en_i & ~isr_i & ~sp_wr_i;

  assign usp_d_o[ISP_W-1:0] = user_wr ? wr_data_i[ISP_W-1:0] : usp_q_i[ISP_W-1:0];

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    logic fl;
    if ((b >= FLAG_LSB) && (b < FLAG_LSB + FLAG_W)) begin : g_flag
      assign fl = flg_bits_i[b-FLAG_LSB];
    end else begin : g_plain
      assign fl = 1'b0;
    end
    assign usp_d_o[ISP_W+b] = take_hi ? wr_data_i[ISP_W+b]
                                      : (usp_q_i[ISP_W+b] | (flag_ok & fl));
  end

  assign isp_d_o = (sp_wr_i & isr_i) ? wr_data_i[ISP_W-1:0] : isp_q_i;
endmodule

// File: rtl/sp_read_path.sv
module sp_read_path
  import sp_bank_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ISP_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             rd_cls_i,
  input  logic             isr_i,
  input  logic             rv_i,
  input  logic [XLEN-1:0]  usp_i,
  input  logic [ISP_W-1:0] isp_i,
  output logic [XLEN-1:0]  rd_data_o
);
  localparam int STAT_W = XLEN - ISP_W;

  logic [XLEN-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (!hit_i) begin
      rd_q <= '0;
    end else if (isr_i) begin
      rd_q <= {{STAT_W{1'b0}}, isp_i};
    end else if (rv_i && is_arith(rd_cls_i)) begin
      rd_q <= {{STAT_W{1'b0}}, usp_i[ISP_W-1:0]};
    end else begin
      rd_q <= usp_i;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit #(
  parameter int XLEN     = 64,
  parameter int ISP_W    = 48,
  parameter int IDX_W    = 6,
  parameter int SP_IDX   = 15,
  parameter int FLAG_W   = 5,
  parameter int FLAG_LSB = 0,
  parameter int FTZ_BIT  = 8,
  parameter int DAZ_BIT  = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_load_i,
  input  logic                   mode_rv_i,
  input  logic                   rd_en_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  input  logic                   rd_cls_i,
  output logic [XLEN-1:0]        rd_data_o,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic                   wr_cls_i,
  input  logic [XLEN-1:0]        wr_data_i,
  input  logic                   flg_en_i,
  input  logic [FLAG_W-1:0]      flg_bits_i,
  input  logic                   irq_enter_i,
  input  logic                   irq_return_i,
  output logic                   isr_o,
  output logic                   nest_err_o,
  output logic [XLEN-ISP_W-1:0]  fpsr_o,
  output logic [1:0]             fpu_mode_o
);
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  logic [XLEN-1:0]  usp_q, usp_d;
  logic [ISP_W-1:0] isp_q, isp_d;
  logic             isr, rv_mode;
  logic             sp_wr, sp_rd;

  assign sp_wr = wr_en_i & (wr_idx_i == SP_SEL);
  assign sp_rd = rd_en_i & (rd_idx_i == SP_SEL);

  sp_isr_ctrl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .irq_enter_i  (irq_enter_i),
    .irq_return_i (irq_return_i),
    .mode_load_i  (mode_load_i),
    .mode_rv_i    (mode_rv_i),
    .isr_o        (isr),
    .nest_err_o   (nest_err_o),
    .rv_mode_o    (rv_mode)
  );

  sp_write_path #(
    .XLEN(XLEN), .ISP_W(ISP_W), .FLAG_W(FLAG_W), .FLAG_LSB(FLAG_LSB)
  ) u_wr (
    .usp_q_i    (usp_q),
    .isp_q_i    (isp_q),
    .isr_i      (isr),
    .rv_i       (rv_mode),
    .sp_wr_i    (sp_wr),
    .wr_cls_i   (wr_cls_i),
    .wr_data_i  (wr_data_i),
    .flg_en_i   (flg_en_i),
    .flg_bits_i (flg_bits_i),
    .usp_d_o    (usp_d),
    .isp_d_o    (isp_d)
  );

  sp_read_path #(
    .XLEN(XLEN), .ISP_W(ISP_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (sp_rd),
    .rd_cls_i  (rd_cls_i),
    .isr_i     (isr),
    .rv_i      (rv_mode),
    .usp_i     (usp_q),
    .isp_i     (isp_q),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      usp_q <= '0;
      isp_q <= '0;
    end else begin
      usp_q <= usp_d;
      isp_q <= isp_d;
    end
  end

  assign isr_o      = isr;
  assign fpsr_o     = usp_q[XLEN-1:ISP_W];
  assign fpu_mode_o = isr ? 2'b11 : {usp_q[ISP_W+DAZ_BIT], usp_q[ISP_W+FTZ_BIT]};
endmodule

// File: rtl/sp_bank_chk.sv
module sp_bank_chk #(
  parameter int XLEN   = 64,
  parameter int ISP_W  = 48,
  parameter int IDX_W  = 6,
  parameter int SP_IDX = 15
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rv_mode,
  input logic                  rd_en_i,
  input logic [IDX_W-1:0]      rd_idx_i,
  input logic                  rd_cls_i,
  input logic [XLEN-1:0]       rd_data_o,
  input logic                  wr_en_i,
  input logic [IDX_W-1:0]      wr_idx_i,
  input logic                  wr_cls_i,
  input logic                  flg_en_i,
  input logic                  irq_enter_i,
  input logic                  isr_o,
  input logic                  nest_err_o,
  input logic [XLEN-ISP_W-1:0] fpsr_o,
  input logic [1:0]            fpu_mode_o
);
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  logic rd_sp, wr_sp;
  assign rd_sp = rd_en_i && (rd_idx_i == SP_SEL);
  assign wr_sp = wr_en_i && (wr_idx_i == SP_SEL);

  assert_isp_read_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (isr_o && rd_sp) |=> (rd_data_o[XLEN-1:ISP_W] == '0));

  assert_enter_sets_isr_R5: assert property (@(posedge clk) disable iff (rst)
    (!isr_o && irq_enter_i) |=> isr_o);

  assert_nested_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (isr_o && irq_enter_i) |=> nest_err_o);

  assert_flags_only_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!isr_o && flg_en_i && !wr_sp) |=> ((fpsr_o & $past(fpsr_o)) == $past(fpsr_o)));

  assert_isr_status_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    isr_o |=> $stable(fpsr_o));

  assert_isr_mode_forced_R10: assert property (@(posedge clk) disable iff (rst)
    isr_o |-> (fpu_mode_o == 2'b11));

  assert_rv_arith_write_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (!isr_o && rv_mode && wr_sp && !wr_cls_i) |=> $stable(fpsr_o));

  assert_rv_arith_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rv_mode && rd_sp && !rd_cls_i) |=> (rd_data_o[XLEN-1:ISP_W] == '0));
endmodule

bind sp_bank_unit sp_bank_chk #(
  .XLEN(XLEN), .ISP_W(ISP_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rv_mode    (rv_mode),
  .rd_en_i    (rd_en_i),
  .rd_idx_i   (rd_idx_i),
  .rd_cls_i   (rd_cls_i),
  .rd_data_o  (rd_data_o),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_cls_i   (wr_cls_i),
  .flg_en_i   (flg_en_i),
  .irq_enter_i(irq_enter_i),
  .isr_o      (isr_o),
  .nest_err_o (nest_err_o),
  .fpsr_o     (fpsr_o),
  .fpu_mode_o (fpu_mode_o)
);

// File: tb/sim_sp_bank_unit.sv
module sim_sp_bank_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] SP = 6'd15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_load, mode_rv, rd_en, rd_cls, wr_en, wr_cls, flg_en, irq_enter, irq_return;
  logic [5:0]  rd_idx, wr_idx;
  logic [63:0] wr_data;
  logic [4:0]  flg_bits;
  logic [63:0] rd_data;
  logic        isr, nest_err;
  logic [15:0] fpsr;
  logic [1:0]  fpu_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_bank_unit u0 (
    .clk(clk), .rst(rst), .mode_load_i(mode_load), .mode_rv_i(mode_rv),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_cls_i(rd_cls), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_cls_i(wr_cls), .wr_data_i(wr_data),
    .flg_en_i(flg_en), .flg_bits_i(flg_bits), .irq_enter_i(irq_enter),
    .irq_return_i(irq_return), .isr_o(isr), .nest_err_o(nest_err),
    .fpsr_o(fpsr), .fpu_mode_o(fpu_mode)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [63:0] m_usp, m_rd;
  logic [47:0] m_isp;
  logic        m_isr, m_rv, m_nest;

  function automatic logic [63:0] f_read(logic hit, logic cls, logic isr_s, logic rv_s,
                                         logic [63:0] usp, logic [47:0] isp);
    if (!hit) return 64'h0;
    if (isr_s) return {16'h0, isp};
    if (rv_s && !cls) return {16'h0, usp[47:0]};
    return usp;
  endfunction

  function automatic logic [1:0] f_mode(logic isr_s, logic [63:0] usp);
    return isr_s ? 2'b11 : {usp[57], usp[56]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    mode_load = 0; mode_rv = 0; rd_en = 0; rd_idx = 0; rd_cls = 0;
    wr_en = 0; wr_idx = 0; wr_cls = 0; wr_data = 0; flg_en = 0; flg_bits = 0;
    irq_enter = 0; irq_return = 0;
  endtask

  // Apply the inputs set by the caller for one cycle and check one edge later.
  task automatic go(input string tag);
    logic sp_wr, sp_rd;
    sp_rd = rd_en && rd_idx == SP;
    sp_wr = wr_en && wr_idx == SP;
    m_rd   = f_read(sp_rd, rd_cls, m_isr, m_rv, m_usp, m_isp);
    m_nest = m_isr && irq_enter;
    if (sp_wr && !m_isr) begin
      if (m_rv && !wr_cls) m_usp = {m_usp[63:48], wr_data[47:0]};
      else m_usp = wr_data;
    end else if (flg_en && !m_isr) begin
      m_usp[52:48] = m_usp[52:48] | flg_bits;
    end
    if (sp_wr && m_isr) m_isp = wr_data[47:0];
    m_isr = m_isr ? !irq_return : irq_enter;
    if (mode_load) m_rv = mode_rv;
    @(negedge clk);
    chk(tag, "rd_data", rd_data, m_rd);
    chk(tag, "fpsr", {48'h0, fpsr}, {48'h0, m_usp[63:48]});
    chk(tag, "isr", {63'h0, isr}, {63'h0, m_isr});
    chk(tag, "nest_err", {63'h0, nest_err}, {63'h0, m_nest});
    chk(tag, "fpu_mode", {62'h0, fpu_mode}, {62'h0, f_mode(m_isr, m_usp)});
    idle();
  endtask

  task automatic wr_sp(input logic cls, input logic [63:0] d);
    wr_en = 1; wr_idx = SP; wr_cls = cls; wr_data = d;
  endtask

  task automatic rd_sp(input logic cls);
    rd_en = 1; rd_idx = SP; rd_cls = cls;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    m_usp = 0; m_isp = 0; m_isr = 0; m_rv = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd_sp(0); go("R1 reset");
    // R3 full native write, R2 readback and status alias
    wr_sp(0, 64'hABCD_0000_1234_5678); go("R3 native write");
    rd_sp(1); go("R2 native read");
    rd_en = 1; rd_idx = 6'd3; go("R2 other index reads zero");
    wr_en = 1; wr_idx = 6'd14; wr_data = 64'hFFFF_FFFF_FFFF_FFFF; go("R3 other index ignored");
    rd_sp(0); go("R3 other index ignored readback");
    // R3 carry into the status field
    wr_sp(0, 64'h0000_FFFF_FFFF_FFFF); go("R3 pre carry");
    wr_sp(0, 64'h0001_0000_0000_0000); go("R3 carry reaches status");
    // R10 mode bits, R7 accumulation
    wr_sp(1, 64'h0300_0000_0000_0040); go("R10 daz ftz set");
    flg_en = 1; flg_bits = 5'b00101; go("R7 flag or");
    flg_en = 1; flg_bits = 5'b10000; go("R7 flag or again");
    flg_en = 1; flg_bits = 5'b11111; wr_en = 1; wr_idx = 6'd7; go("R7 flag with other index write");
    // R9 write wins
    wr_sp(0, 64'h0100_0000_0000_1000); flg_en = 1; flg_bits = 5'b01010; go("R9 write beats flags");
    rd_sp(0); wr_sp(0, 64'h0015_0000_0000_2000); go("R13 read before write");
    // R5 entry and interrupt bank
    irq_enter = 1; rd_sp(0); go("R5 enter");
    rd_sp(0); go("R5 isp visible");
    wr_sp(1, 64'hFFFF_AAAA_BBBB_CCCC); go("R4 isp write");
    rd_sp(1); go("R4 isp read upper zero");
    flg_en = 1; flg_bits = 5'b11111; go("R8 flags dropped in isr");
    go("R10 forced mode");
    irq_enter = 1; go("R6 nested enter");
    go("R6 nest pulse clears");
    irq_return = 1; go("R5 return");
    rd_sp(1); go("R5 user sp restored");
    irq_return = 1; go("R6 stray return ignored");
    // R13 mode load timing, R11 and R12 RISC-V accesses
    mode_load = 1; mode_rv = 1; wr_sp(0, 64'hFFFF_0000_0000_0010); go("R13 mode load old mode");
    rd_sp(0); go("R11 arith read hides status");
    wr_sp(0, 64'h1234_0000_0000_0020); go("R11 arith write keeps status");
    rd_sp(1); go("R12 logic read full");
    wr_sp(1, 64'h0300_0000_0000_0030); go("R12 logic write full");
    flg_en = 1; flg_bits = 5'b00011; go("R7 flags in rv mode");
    mode_load = 1; mode_rv = 0; go("R13 back to native");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      rd_en = r[0] | r[1];
      rd_idx = (r[4:2] != 0) ? SP : 6'($urandom);
      rd_cls = r[5];
      wr_en = r[6] & r[7] | r[8];
      wr_idx = (r[11:9] != 0) ? SP : 6'($urandom);
      wr_cls = r[12];
      wr_data = {$urandom, $urandom};
      if (r[13]) wr_data[63:48] = 16'($urandom) & 16'h031F;
      flg_en = r[14] & r[15] | r[16] & r[17];
      flg_bits = 5'($urandom);
      irq_enter = (r[21:18] == 0);
      irq_return = (r[25:22] == 0);
      mode_load = (r[30:26] == 0);
      mode_rv = r[31];
      go("random R2 R3 R5 R7 R9 R11 R12 R13");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule